// File: doc/BRIEF.md
# Hold-off Event Time Tagger

This block stamps events with a time value and enforces a minimum spacing between the records it produces. The event strobe is a single-cycle indication from an edge detector upstream, and events are counted only while `en` is high. Inside the block a free-running timestamp counter advances once per clock.

When the block is idle, an event opens a hold-off window. That event's cycle becomes the record's time tag, and the event count starts at one. Further events inside the window are added to the count. When the window ends, one record is produced carrying the tag and the merged count. This caps the record rate at one per `holdoff` cycles, and every event is still accounted for.

Records leave through a single output register with a valid/ready handshake. A record stays on `rec_time`/`rec_count` without change while `rec_valid` is high and `rec_ready` is low. It transfers on a clock edge where both signals are high. If a window ends while the output register still holds a record that is not being taken, the window stays open and keeps merging events. It closes in the first cycle in which the register is free. Back-pressure therefore only ever widens the spacing between records. No event is lost, although the count can saturate.

Top module: `hoff_tagger`

## Requirements
- R1: The timestamp is 0 in the first cycle after reset is released. It rises by one every cycle and wraps modulo 2^TSW.
- R2: An enabled event (`en`=1, `evt`=1) in a cycle t0 with no window open opens a window. The record's time tag is the timestamp of cycle t0.
- R3: With H = max(`holdoff`,1), enabled events in cycles t0 to t0+H-1 are merged into one record. The record's count equals the number of those events and is always at least 1. With `rec_ready` held high, `rec_valid` is high in cycle t0+H+1 and the record transfers in that cycle.
- R4: An enabled event in the closing cycle t0+H is not added to the closing record. It opens the next window with a count of 1 and the tag of cycle t0+H.
- R5: No window opens and no record is produced without an enabled event. Events while `en` is low have no effect.
- R6: The record count saturates at 2^CW-1.
- R7: A low `en` ends any open window at the next edge and produces no record. The next enabled event opens a fresh window.
- R8: While `rec_valid` is high and `rec_ready` is low, `rec_valid`, `rec_time` and `rec_count` hold their values.
- R9: If the window is due to close while the output register is occupied and not being read, the window stays open. Enabled events keep adding to its count. It closes in the first cycle in which the register is empty or being read.
- R10: A `holdoff` of 0 behaves exactly like a `holdoff` of 1.
- R11: `rec_valid` is low while reset is applied and in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Counting enable; low clears any open window |
| evt | input | 1 | Single-cycle event strobe |
| holdoff | input | HW | Minimum record spacing in cycles (0 treated as 1) |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_time | output | TSW | Timestamp of the window's first event |
| rec_count | output | CW | Number of events merged into the record |

## Verification
A small configuration (8-bit timestamp, 3-bit count, 4-bit hold-off) is driven with every 8-cycle event mask for each hold-off value from 0 to 5. The expected records are derived from the window rule alone. These patterns separate counting inside the window from counting in the closing cycle (R4). They also separate the zero hold-off case from the other values, and the long run crosses the timestamp wrap several times. Directed sequences cover a long burst that saturates the count, events ignored while disabled, and a window cut short by `en` falling. A stalled output is tested with events arriving while a closure is deferred, which tells a widened window apart from a dropped or early record.

// File: rtl/hoff_pkg.sv
package hoff_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;
endpackage

// File: rtl/hoff_timebase.sv
module hoff_timebase #(
  parameter int TSW = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [TSW-1:0] ts_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) ts_o <= '0;
    else        ts_o <= ts_o + TSW'(1);
  end
endmodule

// File: rtl/hoff_window.sv
module hoff_window
  import hoff_pkg::*;
#(
  parameter int HW  = 32,
  parameter int CW  = 16,
  parameter int TSW = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           evt,
  input  logic [HW-1:0]  holdoff,
  input  logic [TSW-1:0] ts,
  input  logic           out_free,
  output logic           push,
  output logic [TSW-1:0] push_tag,
  output logic [CW-1:0]  push_cnt,
  output logic           active_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  win_state_e      state;
  logic [HW-1:0]   elapsed;
  logic [HW-1:0]   span;
  logic [TSW-1:0]  tag_q;
  logic [CW-1:0]   cnt_q;
  logic            due;
  logic            opening;

  // Zero hold-off collapses to a one-cycle window.
  always_comb span = (holdoff == '0) ? HW'(1) : holdoff;

  always_comb begin
    due     = (state == WIN_OPEN) && (elapsed >= span);
    push    = en && due && out_free;
    opening = en && evt && ((state == WIN_IDLE) || push);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state   <= WIN_IDLE;
      elapsed <= '0;
      cnt_q   <= '0;
      tag_q   <= '0;
    end else if (opening) begin
      state   <= WIN_OPEN;
      elapsed <= HW'(1);
      tag_q   <= ts;
      cnt_q   <= CW'(1);
    end else if (push) begin
      state   <= WIN_IDLE;
      elapsed <= '0;
    end else if (state == WIN_OPEN) begin
      if (!due) elapsed <= elapsed + HW'(1);
      if (evt && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign push_tag = tag_q;
  assign push_cnt = cnt_q;
  assign active_o = (state == WIN_OPEN);
endmodule

// File: rtl/hoff_outreg.sv
module hoff_outreg #(
  parameter int TSW = 48,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [TSW-1:0] push_tag,
  input  logic [CW-1:0]  push_cnt,
  output logic           out_free,
  output logic           rec_valid,
  input  logic           rec_ready,
  output logic [TSW-1:0] rec_time,
  output logic [CW-1:0]  rec_count
);
  always_comb out_free = !rec_valid || rec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_time  <= '0;
      rec_count <= '0;
    end else if (push) begin
      rec_valid <= 1'b1;
      rec_time  <= push_tag;
      rec_count <= push_cnt;
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hoff_tagger.sv
module hoff_tagger #(
  parameter int TSW = 48,
  parameter int CW  = 16,
  parameter int HW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           evt,
  input  logic [HW-1:0]  holdoff,
  output logic           rec_valid,
  input  logic           rec_ready,
  output logic [TSW-1:0] rec_time,
  output logic [CW-1:0]  rec_count
);
  logic [TSW-1:0] ts;
  logic           out_free;
  logic           push;
  logic [TSW-1:0] push_tag;
  logic [CW-1:0]  push_cnt;
  logic           win_active;

  hoff_timebase #(.TSW(TSW)) u_tb (
    .clk  (clk),
    .rst_n(rst_n),
    .ts_o (ts)
  );

  hoff_window #(.HW(HW), .CW(CW), .TSW(TSW)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .evt     (evt),
    .holdoff (holdoff),
    .ts      (ts),
    .out_free(out_free),
    .push    (push),
    .push_tag(push_tag),
    .push_cnt(push_cnt),
    .active_o(win_active)
  );

  hoff_outreg #(.TSW(TSW), .CW(CW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_tag (push_tag),
    .push_cnt (push_cnt),
    .out_free (out_free),
    .rec_valid(rec_valid),
    .rec_ready(rec_ready),
    .rec_time (rec_time),
    .rec_count(rec_count)
  );
endmodule

// File: rtl/hoff_tagger_chk.sv
module hoff_tagger_chk #(
  parameter int TSW = 48,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           evt,
  input logic           rec_valid,
  input logic           rec_ready,
  input logic [TSW-1:0] rec_time,
  input logic [CW-1:0]  rec_count,
  input logic           win_active
);
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_time) && $stable(rec_count));

  p_count_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_count != '0);

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !win_active);

  p_open_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_active) && win_active |-> $past(evt && en));

  p_quiet_after_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !rec_valid);
endmodule

bind hoff_tagger hoff_tagger_chk #(.TSW(TSW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .evt       (evt),
  .rec_valid (rec_valid),
  .rec_ready (rec_ready),
  .rec_time  (rec_time),
  .rec_count (rec_count),
  .win_active(win_active)
);

// File: tb/tb_hoff_tagger.sv
`timescale 1ns/1ps
module tb_hoff_tagger;
  localparam int TSW = 8;
  localparam int CW  = 3;
  localparam int HW  = 4;
  localparam int TMASK = (1 << TSW) - 1;
  localparam int CMAX  = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic           evt = 1'b0;
  logic [HW-1:0]  holdoff = '0;
  logic           rec_valid;
  logic           rec_ready = 1'b1;
  logic [TSW-1:0] rec_time;
  logic [CW-1:0]  rec_count;

  int checks = 0;
  int errors = 0;
  int now = 0;
  int cap_n = 0;
  int cap_t [16];
  int cap_tag [16];
  int cap_c [16];

  always #4 clk = ~clk;

  hoff_tagger #(.TSW(TSW), .CW(CW), .HW(HW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .evt(evt), .holdoff(holdoff),
    .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_time(rec_time), .rec_count(rec_count)
  );

  // Handshake monitor: records which cycle each transfer happened in.
  always @(posedge clk) begin
    if (!rst_n) now = 0;
    else begin
      if (rec_valid && rec_ready && cap_n < 16) begin
        cap_t[cap_n]   = now;
        cap_tag[cap_n] = int'(rec_time);
        cap_c[cap_n]   = int'(rec_count);
        cap_n = cap_n + 1;
      end
      now = now + 1;
    end
  end

  task automatic check(input string lbl, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", lbl, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One 8-cycle event mask under a given hold-off, checked against the window rule.
  task automatic run_pattern(input int h, input int mask);
    int base, eh, n_exp, t0, cnt;
    bit open;
    int et [16];
    int etag [16];
    int ec [16];
    eh = (h == 0) ? 1 : h;
    holdoff = HW'(h);
    cap_n = 0;
    base = now;
    n_exp = 0; open = 0; t0 = 0; cnt = 0;
    for (int i = 0; i < 8 + eh + 2; i++) begin
      bit b;
      b = (i < 8) ? mask[i] : 1'b0;
      if (open && i == t0 + eh) begin
        et[n_exp] = base + t0 + eh + 1;
        etag[n_exp] = (base + t0) & TMASK;
        ec[n_exp] = (cnt > CMAX) ? CMAX : cnt;
        n_exp++;
        open = 0;
      end
      if (b) begin
        if (!open) begin open = 1; t0 = i; cnt = 1; end
        else cnt++;
      end
    end
    for (int i = 0; i < 8; i++) begin
      evt = mask[i];
      @(negedge clk);
    end
    evt = 1'b0;
    repeat (h + 4) @(negedge clk);
    check($sformatf("R3 R5 record count h=%0d mask=%0h", h, mask), cap_n, n_exp);
    for (int k = 0; k < n_exp && k < cap_n; k++) begin
      check($sformatf("R1 R2 tag h=%0d mask=%0h #%0d", h, mask, k), cap_tag[k], etag[k]);
      check($sformatf("R3 R4 R6 count h=%0d mask=%0h #%0d", h, mask, k), cap_c[k], ec[k]);
      check($sformatf("R3 R10 cycle h=%0d mask=%0h #%0d", h, mask, k), cap_t[k], et[k]);
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    check("R11 valid in reset", rec_valid, 0);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    check("R11 valid after reset", rec_valid, 0);
    repeat (2) @(negedge clk);

    // Exhaustive masks over a range of hold-off values (R1..R4, R10).
    for (int h = 0; h <= 5; h++)
      for (int m = 0; m < 256; m++)
        run_pattern(h, m);

    // R6: long burst saturates the count.
    holdoff = HW'(12);
    cap_n = 0;
    t0 = now;
    evt = 1'b1;
    repeat (10) @(negedge clk);
    evt = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 saturation records", cap_n, 1);
    check("R6 saturated count", cap_c[0], CMAX);
    check("R6 saturation tag", cap_tag[0], t0 & TMASK);
    check("R6 saturation cycle", cap_t[0], t0 + 13);

    // R5: events with enable low do nothing.
    holdoff = HW'(2);
    cap_n = 0;
    en = 1'b0;
    evt = 1'b1;
    repeat (5) @(negedge clk);
    evt = 1'b0;
    repeat (8) @(negedge clk);
    check("R5 no record while disabled", cap_n, 0);
    check("R5 valid low while disabled", rec_valid, 0);
    en = 1'b1;

    // R7: dropping enable kills an open window silently.
    holdoff = HW'(6);
    cap_n = 0;
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (10) @(negedge clk);
    check("R7 no record after disable", cap_n, 0);
    t0 = now;
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
    repeat (9) @(negedge clk);
    check("R7 fresh window records", cap_n, 1);
    check("R7 fresh window tag", cap_tag[0], t0 & TMASK);
    check("R7 fresh window count", cap_c[0], 1);
    check("R7 fresh window cycle", cap_t[0], t0 + 7);

    // R8/R9: output stalled while a second window is due.
    holdoff = HW'(2);
    cap_n = 0;
    rec_ready = 1'b0;
    t0 = now;
    for (int k = 0; k <= 16; k++) begin
      evt = (k == 0 || k == 5 || k == 8 || k == 9 || k == 12);
      rec_ready = (k >= 12);
      if (k >= 4 && k <= 11) begin
        check($sformatf("R8 valid held k=%0d", k), rec_valid, 1);
        check($sformatf("R8 time held k=%0d", k), rec_time, t0 & TMASK);
        check($sformatf("R8 count held k=%0d", k), rec_count, 1);
      end
      @(negedge clk);
    end
    evt = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 stall records", cap_n, 3);
    check("R8 first cycle", cap_t[0], t0 + 12);
    check("R9 second tag", cap_tag[1], (t0 + 5) & TMASK);
    check("R9 second count merged", cap_c[1], 3);
    check("R9 second cycle", cap_t[1], t0 + 13);
    check("R4 third tag", cap_tag[2], (t0 + 12) & TMASK);
    check("R4 third count", cap_c[2], 1);
    check("R9 third cycle", cap_t[2], t0 + 15);

    summary();
    $finish;
  end
endmodule